// File: doc/BRIEF.md
# Scoreboard Issue Hazard Controller

This block is the central hazard bookkeeping for a small out-of-order floating-point pipeline. It has four functional units by default: one integer/load unit, two multipliers and one adder. It keeps one status entry per unit and a table that maps each register to the unit that will write it. Every cycle it decides three things: whether the next in-order instruction may issue, which issued instructions may read their operands, and which finished unit may write its result back. The arithmetic, the register file contents and instruction fetch are outside this block.

Decoded instructions arrive on a valid/ready stream. An instruction is accepted in a cycle where `in_valid` and `in_ready` are both high. While `in_valid` is high and `in_ready` is low, the source must hold the instruction unchanged. `in_ready` is computed from the payload and the current state and never depends on `in_valid`. Execution units report completion with a one-cycle `fu_done` pulse. The block answers with a one-cycle `rd_grant` pulse when a unit may read its operands and a one-cycle `wb_grant` pulse when a unit may write its result. There is no renaming. Output (WAW) conflicts are resolved by holding the instruction at issue, and anti (WAR) conflicts are resolved by holding the result at write-back.

Unit index map, used in every unit vector below: bit 0 is the integer/load unit, bits 1 to NUM_MUL are the multipliers, and the top bit is the adder.

Top module: `sb_scoreboard`

## Requirements
- R1: After reset, or after a reset in the middle of a run, no unit is busy and no register has a pending writer. `rd_grant` and `wb_grant` are 0, and `in_ready` is 1 for every opcode class and every destination.
- R2: An instruction whose destination register already has a pending writer is held (`in_ready` low). It is accepted in the cycle after that writer's `wb_grant`.
- R3: Opcode class 0 goes to unit bit 0, class 1 goes to the lowest-numbered free multiplier, and classes 2 and 3 go to the adder. The unit is reported one-hot on `iss_unit` during the handshake. If the required unit (or every multiplier) is busy, `in_ready` is low.
- R4: If neither source of an instruction has a pending writer, its unit receives `rd_grant` in the cycle after issue, and only for that one cycle.
- R5: If a source has a pending writer, the unit gets no `rd_grant` until that writer is granted write-back. `rd_grant` then follows in the next cycle, provided the other source is ready.
- R6: A `fu_done` pulse to a unit that has read its operands produces that unit's `wb_grant` in the next cycle, with `wb_dst` equal to the destination register. The unit and the register are free in the cycle after the grant.
- R7: A unit's write-back is withheld while any other unit still has the same register as an unread, ready source. It is granted in the cycle after that operand read.
- R8: At most one `wb_grant` bit is set in a cycle. Among the units that may write back, the lowest unit index wins.
- R9: A `fu_done` pulse to a unit that is idle, being allocated, or waiting for operands has no effect. No later `wb_grant` comes from it.
- R10: If an instruction issues in the same cycle as the `wb_grant` of its source's producer, it treats that source as ready and receives `rd_grant` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Instruction may issue this cycle |
| in_op | input | 2 | Opcode class: 0 integer/load, 1 multiply, 2 or 3 add |
| in_dst | input | RW | Destination register |
| in_src_a | input | RW | First source register |
| in_src_b | input | RW | Second source register |
| fu_done | input | NFU | Per-unit execution-finished pulse |
| iss_unit | output | NFU | One-hot unit receiving the instruction during the handshake |
| rd_grant | output | NFU | Per-unit operand-read grant |
| wb_grant | output | NFU | Per-unit write-back grant, at most one bit |
| wb_dst | output | RW | Destination register of the granted write-back |

## Verification
The bound checker watches the per-cycle invariants. It confirms that write-back grants are never more than one-hot and come only from busy units, that every accepted instruction lands on a free unit whose destination has no writer in flight, that an operand read is never granted twice in a row, and that a granted unit is idle on the following cycle. The timing relations can only be seen in the bench's scenarios. These are: the exact cycle a held WAR write-back is released after the reader takes its operand, the wake-up of a RAW-blocked reader one cycle after its producer writes, the same-cycle issue forwarding, the order of several simultaneous write-back requests, and the fact that stray done pulses are ignored.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    FU_IDLE = 2'd0,
    FU_READ = 2'd1,
    FU_EXEC = 2'd2,
    FU_WB   = 2'd3
  } fu_state_e;

  localparam logic [1:0] OP_INT = 2'd0;
  localparam logic [1:0] OP_MUL = 2'd1;
endpackage

// File: rtl/sb_regstat.sv
module sb_regstat #(
  parameter int NUM_REGS = 16,
  parameter int RW       = 4,
  parameter int TAGW     = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [RW-1:0]   set_reg,
  input  logic [TAGW-1:0] set_tag,
  input  logic            clr_en,
  input  logic [RW-1:0]   clr_reg,
  input  logic [RW-1:0]   rd_a,
  input  logic [RW-1:0]   rd_b,
  input  logic [RW-1:0]   rd_c,
  output logic [TAGW-1:0] tag_a,
  output logic [TAGW-1:0] tag_b,
  output logic [TAGW-1:0] tag_c
);
  // Writer tag per register; zero means no writer in flight.
  logic [TAGW-1:0] owner [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) owner[r] <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (set_en && set_reg == RW'(r))      owner[r] <= set_tag;
        else if (clr_en && clr_reg == RW'(r)) owner[r] <= '0;
      end
    end
  end

  assign tag_a = owner[rd_a];
  assign tag_b = owner[rd_b];
  assign tag_c = owner[rd_c];
endmodule

// File: rtl/sb_issue_sel.sv
module sb_issue_sel import sb_pkg::*; #(
  parameter int NUM_MUL = 2,
  parameter int NFU     = NUM_MUL + 2
) (
  input  logic           in_valid,
  input  logic [1:0]     in_op,
  input  logic [NFU-1:0] busy,
  input  logic           dst_free,
  output logic           ready,
  output logic [NFU-1:0] sel
);
  logic [NFU-1:0] cand;
  logic           found;

  always_comb begin
    cand  = '0;
    found = 1'b0;
    if (in_op == OP_INT) begin
      cand[0] = !busy[0];
    end else if (in_op == OP_MUL) begin
      for (int i = 1; i <= NUM_MUL; i++) begin
        if (!busy[i] && !found) begin
          cand[i] = 1'b1;
          found   = 1'b1;
        end
      end
    end else begin
      cand[NFU-1] = !busy[NFU-1];
    end
  end

  assign ready = dst_free && (|cand);
  assign sel   = (in_valid && ready) ? cand : '0;
endmodule

// File: rtl/sb_fu_entry.sv
module sb_fu_entry import sb_pkg::*; #(
  parameter int RW   = 4,
  parameter int TAGW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc,
  input  logic [RW-1:0]   a_fi,
  input  logic [RW-1:0]   a_fj,
  input  logic [RW-1:0]   a_fk,
  input  logic [TAGW-1:0] a_qj,
  input  logic [TAGW-1:0] a_qk,
  input  logic            bc_valid,
  input  logic [TAGW-1:0] bc_tag,
  input  logic            done_in,
  input  logic            wb_win,
  output logic            busy,
  output logic            rd_go,
  output logic            wb_req,
  output logic [RW-1:0]   fi,
  output logic [RW-1:0]   fj,
  output logic [RW-1:0]   fk,
  output logic            rj,
  output logic            rk
);
  fu_state_e       state;
  logic [TAGW-1:0] qj, qk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= FU_IDLE;
      fi    <= '0;
      fj    <= '0;
      fk    <= '0;
      qj    <= '0;
      qk    <= '0;
      rj    <= 1'b0;
      rk    <= 1'b0;
    end else if (wb_win) begin
      state <= FU_IDLE;
    end else if (alloc) begin
      state <= FU_READ;
      fi    <= a_fi;
      fj    <= a_fj;
      fk    <= a_fk;
      qj    <= a_qj;
      qk    <= a_qk;
      rj    <= (a_qj == '0);
      rk    <= (a_qk == '0);
    end else begin
      unique case (state)
        FU_READ: begin
          if (rj && rk) begin
            state <= FU_EXEC;
            rj    <= 1'b0;
            rk    <= 1'b0;
          end else begin
            if (bc_valid && qj != '0 && qj == bc_tag) begin
              qj <= '0;
              rj <= 1'b1;
            end
            if (bc_valid && qk != '0 && qk == bc_tag) begin
              qk <= '0;
              rk <= 1'b1;
            end
          end
        end
        FU_EXEC: if (done_in) state <= FU_WB;
        default: ;
      endcase
    end
  end

  assign busy   = (state != FU_IDLE);
  assign rd_go  = (state == FU_READ) && rj && rk;
  assign wb_req = (state == FU_WB);
endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb #(
  parameter int NFU  = 4,
  parameter int RW   = 4,
  parameter int TAGW = 3
) (
  input  logic [NFU-1:0]         wb_req,
  input  logic [NFU-1:0][RW-1:0] fi,
  input  logic [NFU-1:0][RW-1:0] fj,
  input  logic [NFU-1:0][RW-1:0] fk,
  input  logic [NFU-1:0]         rj,
  input  logic [NFU-1:0]         rk,
  output logic [NFU-1:0]         grant,
  output logic                   g_valid,
  output logic [TAGW-1:0]        g_tag,
  output logic [RW-1:0]          g_dst
);
  logic [NFU-1:0] blocked;
  logic [NFU-1:0] elig;

  // Anti-dependence hold: another unit still wants the old register value.
  always_comb begin
    for (int u = 0; u < NFU; u++) begin
      blocked[u] = 1'b0;
      for (int v = 0; v < NFU; v++) begin
        if (v != u && ((rj[v] && fj[v] == fi[u]) || (rk[v] && fk[v] == fi[u])))
          blocked[u] = 1'b1;
      end
    end
  end

  assign elig = wb_req & ~blocked;

  always_comb begin
    grant   = '0;
    g_valid = 1'b0;
    g_tag   = '0;
    g_dst   = '0;
    for (int u = 0; u < NFU; u++) begin
      if (elig[u] && !g_valid) begin
        grant[u] = 1'b1;
        g_valid  = 1'b1;
        g_tag    = TAGW'(u + 1);
        g_dst    = fi[u];
      end
    end
  end
endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard #(
  parameter  int NUM_REGS = 16,
  parameter  int NUM_MUL  = 2,
  localparam int NFU      = NUM_MUL + 2,
  localparam int RW       = $clog2(NUM_REGS),
  localparam int TAGW     = $clog2(NFU + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [1:0]     in_op,
  input  logic [RW-1:0]  in_dst,
  input  logic [RW-1:0]  in_src_a,
  input  logic [RW-1:0]  in_src_b,
  input  logic [NFU-1:0] fu_done,
  output logic [NFU-1:0] iss_unit,
  output logic [NFU-1:0] rd_grant,
  output logic [NFU-1:0] wb_grant,
  output logic [RW-1:0]  wb_dst
);
  logic [NFU-1:0]         busy_v, rd_go, wb_req, rj_v, rk_v, sel, grant;
  logic [NFU-1:0][RW-1:0] fi_all, fj_all, fk_all;
  logic [TAGW-1:0]        tag_a, tag_b, tag_d, q_a, q_b, sel_tag, wb_tag;
  logic [RW-1:0]          g_dst;
  logic                   wb_valid;

  always_comb begin
    sel_tag = '0;
    for (int u = 0; u < NFU; u++) if (sel[u]) sel_tag = TAGW'(u + 1);
  end

  sb_regstat #(.NUM_REGS(NUM_REGS), .RW(RW), .TAGW(TAGW)) u_rs (
    .clk(clk), .rst_n(rst_n),
    .set_en(|sel), .set_reg(in_dst), .set_tag(sel_tag),
    .clr_en(wb_valid), .clr_reg(g_dst),
    .rd_a(in_src_a), .rd_b(in_src_b), .rd_c(in_dst),
    .tag_a(tag_a), .tag_b(tag_b), .tag_c(tag_d)
  );

  sb_issue_sel #(.NUM_MUL(NUM_MUL), .NFU(NFU)) u_sel (
    .in_valid(in_valid), .in_op(in_op), .busy(busy_v),
    .dst_free(tag_d == '0), .ready(in_ready), .sel(sel)
  );

  // A producer writing back this very cycle counts as already delivered.
  assign q_a = (wb_valid && tag_a == wb_tag) ? '0 : tag_a;
  assign q_b = (wb_valid && tag_b == wb_tag) ? '0 : tag_b;

  for (genvar u = 0; u < NFU; u++) begin : g_fu
    sb_fu_entry #(.RW(RW), .TAGW(TAGW)) u_ent (
      .clk(clk), .rst_n(rst_n),
      .alloc(sel[u]),
      .a_fi(in_dst), .a_fj(in_src_a), .a_fk(in_src_b),
      .a_qj(q_a), .a_qk(q_b),
      .bc_valid(wb_valid), .bc_tag(wb_tag),
      .done_in(fu_done[u]), .wb_win(grant[u]),
      .busy(busy_v[u]), .rd_go(rd_go[u]), .wb_req(wb_req[u]),
      .fi(fi_all[u]), .fj(fj_all[u]), .fk(fk_all[u]),
      .rj(rj_v[u]), .rk(rk_v[u])
    );
  end

  sb_wb_arb #(.NFU(NFU), .RW(RW), .TAGW(TAGW)) u_arb (
    .wb_req(wb_req), .fi(fi_all), .fj(fj_all), .fk(fk_all),
    .rj(rj_v), .rk(rk_v),
    .grant(grant), .g_valid(wb_valid), .g_tag(wb_tag), .g_dst(g_dst)
  );

  assign iss_unit = sel;
  assign rd_grant = rd_go;
  assign wb_grant = grant;
  assign wb_dst   = g_dst;
endmodule

// File: rtl/sb_scoreboard_chk.sv
module sb_scoreboard_chk #(
  parameter int NFU = 4,
  parameter int RW  = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [RW-1:0]          in_dst,
  input logic [NFU-1:0]         iss_unit,
  input logic [NFU-1:0]         rd_grant,
  input logic [NFU-1:0]         wb_grant,
  input logic [NFU-1:0]         busy_v,
  input logic [NFU-1:0][RW-1:0] fi_all
);
  logic waw_hit;
  always_comb begin
    waw_hit = 1'b0;
    for (int u = 0; u < NFU; u++)
      if (busy_v[u] && fi_all[u] == in_dst) waw_hit = 1'b1;
  end

  AST_WB_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wb_grant)); // R8
  AST_ISSUE_FREE_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> ($onehot(iss_unit) && (iss_unit & busy_v) == '0)); // R3
  AST_ISSUE_NO_WAW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> !waw_hit); // R2
  AST_READ_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_grant != '0) |=> ((rd_grant & $past(rd_grant)) == '0)); // R4
  AST_WB_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_grant & ~busy_v) == '0); // R6
  AST_WB_FREES_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_grant != '0) |=> ((busy_v & $past(wb_grant)) == '0)); // R6
endmodule

bind sb_scoreboard sb_scoreboard_chk #(.NFU(NFU), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_dst(in_dst), .iss_unit(iss_unit), .rd_grant(rd_grant),
  .wb_grant(wb_grant), .busy_v(busy_v), .fi_all(fi_all)
);

// File: tb/tb_sb_scoreboard.sv
module tb_sb_scoreboard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_op = 2'd0;
  logic [3:0] in_dst = 4'd0, in_src_a = 4'd0, in_src_b = 4'd0;
  logic [3:0] fu_done = 4'd0;
  logic [3:0] iss_unit, rd_grant, wb_grant;
  logic [3:0] wb_dst;
  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  sb_scoreboard dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .fu_done(fu_done), .iss_unit(iss_unit), .rd_grant(rd_grant),
    .wb_grant(wb_grant), .wb_dst(wb_dst)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at the falling edge, then sample once the combinational outputs settle.
  task automatic drive(input logic v, input int op, input int d, input int sa,
                       input int sb, input int dn);
    @(negedge clk);
    in_valid = v;
    in_op    = 2'(op);
    in_dst   = 4'(d);
    in_src_a = 4'(sa);
    in_src_b = 4'(sb);
    fu_done  = 4'(dn);
    #2;
  endtask

  task automatic idle();
    drive(1'b0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    for (int op = 0; op < 4; op++) begin
      drive(1'b0, op, op * 5, 0, 1, 0);
      chk("R1 ready after reset", in_ready, 1);
      chk("R1 no read grant", rd_grant, 0);
      chk("R1 no wb grant", wb_grant, 0);
    end

    // R3 R4 R6: sweep every class and every destination through an idle scoreboard
    for (int op = 0; op < 4; op++) begin
      for (int d = 0; d < 16; d++) begin
        int eu;
        eu = (op == 0) ? 1 : (op == 1) ? 2 : 8;
        drive(1'b1, op, d, (d + 1) % 16, (d + 2) % 16, 0);
        chk("R3 ready on idle", in_ready, 1);
        chk("R3 unit routing", iss_unit, eu);
        drive(1'b0, 0, 0, 0, 0, 0);
        chk("R4 read next cycle", rd_grant, eu);
        drive(1'b0, 0, 0, 0, 0, eu);
        chk("R6 no wb before done", wb_grant, 0);
        drive(1'b0, 0, 0, 0, 0, 0);
        chk("R6 wb after done", wb_grant, eu);
        chk("R6 wb destination", wb_dst, d);
      end
    end

    // R3: structural stall on multipliers
    drive(1'b1, 1, 1, 8, 9, 0);  chk("R3 first mul", iss_unit, 2);
    drive(1'b1, 1, 2, 8, 9, 0);  chk("R3 second mul", iss_unit, 4);
    drive(1'b1, 1, 3, 8, 9, 0);  chk("R3 mul stall", in_ready, 0);
    drive(1'b0, 0, 0, 0, 0, 6);
    drive(1'b0, 0, 0, 0, 0, 0);  chk("R8 mul1 first", wb_grant, 2);
    drive(1'b0, 0, 0, 0, 0, 0);  chk("R8 mul2 second", wb_grant, 4);
    drive(1'b1, 1, 3, 8, 9, 0);  chk("R3 mul freed", iss_unit, 2);
    drive(1'b0, 0, 0, 0, 0, 0);  chk("R4 read", rd_grant, 2);
    drive(1'b0, 0, 0, 0, 0, 2);
    drive(1'b0, 0, 0, 0, 0, 0);  chk("R6 wb", wb_grant, 2);

    // R2: output-dependence stall
    drive(1'b1, 0, 2, 10, 11, 0); chk("R2 first writer", iss_unit, 1);
    drive(1'b1, 2, 2, 12, 13, 0); chk("R2 waw stall", in_ready, 0);
    drive(1'b1, 2, 2, 12, 13, 1); chk("R2 waw stall", in_ready, 0);
    drive(1'b1, 2, 2, 12, 13, 0); chk("R2 stall during wb", in_ready, 0);
    chk("R6 load wb", wb_grant, 1);
    drive(1'b1, 2, 2, 12, 13, 0); chk("R2 released", iss_unit, 8);
    drive(1'b0, 0, 0, 0, 0, 0);   chk("R4 read", rd_grant, 8);
    drive(1'b0, 0, 0, 0, 0, 8);
    drive(1'b0, 0, 0, 0, 0, 0);   chk("R6 wb", wb_grant, 8);
    chk("R6 wb destination", wb_dst, 2);

    // R5 R7: true dependence wake-up and anti-dependence hold
    drive(1'b1, 0, 2, 10, 11, 0); chk("R3 load", iss_unit, 1);
    drive(1'b1, 1, 8, 2, 6, 0);   chk("R3 mul", iss_unit, 2);
    chk("R4 load reads", rd_grant, 1);
    drive(1'b1, 2, 6, 12, 13, 0); chk("R7 no issue stall on war", iss_unit, 8);
    chk("R5 mul waits", rd_grant, 0);
    drive(1'b0, 0, 0, 0, 0, 0);   chk("R5 only add reads", rd_grant, 8);
    drive(1'b0, 0, 0, 0, 0, 8);   chk("R6 no wb", wb_grant, 0);
    drive(1'b0, 0, 0, 0, 0, 0);   chk("R7 war hold", wb_grant, 0);
    drive(1'b0, 0, 0, 0, 0, 1);   chk("R7 war hold", wb_grant, 0);
    drive(1'b0, 0, 0, 0, 0, 0);   chk("R7 load may write", wb_grant, 1);
    chk("R5 mul still waits", rd_grant, 0);
    drive(1'b0, 0, 0, 0, 0, 0);   chk("R5 mul wakes", rd_grant, 2);
    chk("R7 still held", wb_grant, 0);
    drive(1'b0, 0, 0, 0, 0, 0);   chk("R7 released", wb_grant, 8);
    chk("R7 wb destination", wb_dst, 6);
    drive(1'b0, 0, 0, 0, 0, 2);
    drive(1'b0, 0, 0, 0, 0, 0);   chk("R6 mul wb", wb_grant, 2);
    chk("R6 wb destination", wb_dst, 8);

    // R8: four simultaneous write-back requests
    drive(1'b1, 0, 1, 9, 10, 0);
    drive(1'b1, 1, 2, 9, 10, 0);
    drive(1'b1, 1, 3, 9, 10, 0);
    drive(1'b1, 2, 4, 9, 10, 0);
    idle();
    drive(1'b0, 0, 0, 0, 0, 15);
    for (int k = 0; k < 4; k++) begin
      idle();
      chk("R8 priority order", wb_grant, 1 << k);
      chk("R8 wb destination", wb_dst, k + 1);
    end

    // R9: stray done pulses
    drive(1'b0, 0, 0, 0, 0, 15);
    idle();                       chk("R9 idle done ignored", wb_grant, 0);
    idle();                       chk("R9 idle done ignored", wb_grant, 0);
    drive(1'b1, 0, 5, 9, 10, 0);  chk("R3 load", iss_unit, 1);
    drive(1'b1, 2, 6, 5, 9, 8);   chk("R3 add", iss_unit, 8);
    drive(1'b0, 0, 0, 0, 0, 8);
    idle();                       chk("R9 waiting done ignored", wb_grant, 0);
    drive(1'b0, 0, 0, 0, 0, 1);
    idle();                       chk("R6 load wb", wb_grant, 1);
    idle();                       chk("R5 add wakes", rd_grant, 8);
    idle();                       chk("R9 no stale wb", wb_grant, 0);
    drive(1'b0, 0, 0, 0, 0, 8);
    idle();                       chk("R6 add wb", wb_grant, 8);

    // R10: issue in the producer's write-back cycle
    drive(1'b1, 0, 3, 9, 10, 0);
    idle();                       chk("R4 read", rd_grant, 1);
    drive(1'b0, 0, 0, 0, 0, 1);
    drive(1'b1, 2, 5, 3, 4, 0);   chk("R10 producer wb", wb_grant, 1);
    chk("R10 issue accepted", iss_unit, 8);
    idle();                       chk("R10 forwarded read", rd_grant, 8);
    drive(1'b0, 0, 0, 0, 0, 8);
    idle();                       chk("R6 add wb", wb_grant, 8);
    chk("R6 wb destination", wb_dst, 5);

    // R1: reset with work in flight
    drive(1'b1, 0, 1, 9, 10, 0);
    drive(1'b1, 1, 7, 1, 2, 0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 0, 1, 0, 0, 0);   chk("R1 load dst free", in_ready, 1);
    drive(1'b0, 1, 7, 0, 0, 0);   chk("R1 mul free", in_ready, 1);
    chk("R1 no read", rd_grant, 0);
    chk("R1 no wb", wb_grant, 0);

    summary();
    $finish;
  end
endmodule